// File: doc/BRIEF.md
# Flag Pin Controller

This block owns the discrete flag pins of a processor core. A single flag input pin is synchronised and captured into a status bit. The sequencer tests that bit as a branch condition in two polarities: flag set, and flag clear. Four flag outputs are updated by a conditional modify-flag operation. Output 0 is the general-purpose output shared with the serial port. Outputs 1 to 3 are dedicated. The operation carries a 2-bit action code for each output and takes effect only when the sequencer reports its condition as true.

Eight programmable flags can each be an input or an output. Software sets their direction and their data through a small register bus. A read of the data register returns the latched drive value for pins set as outputs. For pins set as inputs it returns the synchronised pin value. A bit of the system control word decides whether the shared serial-port pins serve as flags and interrupt lines. The flag input is only captured while that mode is on. The block also tells the loop-counter logic when a counter-expired test may decrement the counter: a modify-flag operation evaluating that condition must leave the counter alone.

Top module: `flagpin_ctrl`

## Requirements
- R1: `fi_pin_i` passes through two synchroniser flops. While `alt_mode_o` is 1, each clock edge loads the synchroniser output into the flag-in status. The status therefore follows the pin three edges later. While `alt_mode_o` is 0 the status holds. `br_flag_in_o` equals the status, and `br_not_flag_in_o` is its complement.
- R2: On a clock edge where `mod_strobe_i` and `cond_true_i` are both 1, every flag output applies its own action code. The codes sit in `flag_act_i`: output 0 in bits [1:0], output 1 in [3:2], output 2 in [5:4] and output 3 in [7:6]. Code 00 keeps the value, 01 sets it, 10 clears it and 11 inverts it. All outputs change together on that edge.
- R3: A strobe with `cond_true_i` at 0 leaves every flag output unchanged.
- R4: `lc_dec_o` is 1 when `ce_eval_i` is 1 and `mod_strobe_i` is 0. It is 0 whenever `mod_strobe_i` is 1.
- R5: Reset sets flag outputs 1 to 3 to 1. Flag output 0 keeps the value it had before reset. No modify-flag operation takes effect while reset is high.
- R6: A read at bus address 1 returns flag output 0 in bit 0, with all other bits 0. Writes to address 1 change nothing.
- R7: Address 0 holds the 16-bit system control word. It resets to 0 and reads back as written. Its bit 10 drives `alt_mode_o`: 1 selects the flag and interrupt function of the shared pins.
- R8: Address 2 bits [7:0] form the direction register. A 1 makes a programmable flag an output. The register resets to 0, so every flag starts as an input, and `pf_oe_o` shows it.
- R9: A read at address 3 returns, in bits [7:0], the drive latch for each output pin and the two-flop-synchronised pin value for each input pin.
- R10: Writes to address 3 update all eight drive latches, including those of pins that are currently inputs. `pf_out_o` always shows the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fi_pin_i | input | 1 | Flag input pin |
| mod_strobe_i | input | 1 | Modify-flag operation this cycle |
| cond_true_i | input | 1 | Condition of the current operation is true |
| ce_eval_i | input | 1 | Current instruction evaluates counter-expired |
| flag_act_i | input | 8 | Per-output action codes |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Register write data |
| pf_pin_i | input | 8 | Programmable flag pin levels |
| flag_out_o | output | 4 | Flag outputs (bit 0 shared output) |
| flag_in_o | output | 1 | Captured flag-in status |
| br_flag_in_o | output | 1 | Branch condition: flag set |
| br_not_flag_in_o | output | 1 | Branch condition: flag clear |
| lc_dec_o | output | 1 | Loop counter may decrement |
| alt_mode_o | output | 1 | Shared pins act as flags and interrupts |
| pf_oe_o | output | 8 | Programmable flag output enables |
| pf_out_o | output | 8 | Programmable flag drive values |
| bus_rdata_o | output | 16 | Register read data |

## Verification
The modify-flag path is driven first with one operation that mixes all four action codes. This separates the decoding of set, clear, toggle and keep, and shows any mix-up of field positions. The bench then repeats a toggle-all code with the condition false and again with it true, which separates condition gating from the action itself. Programmable flags are tested with a fixed pin pattern under a mixed direction mask, which shows whether each bit selects between latch and synchronised pin. A long stretch of random operations, pin levels and register writes is compared on every clock against a behavioural model. Reset is applied with flag output 0 at each level to show that it is left untouched.

// File: rtl/flagpin_pkg.sv
package flagpin_pkg;

    localparam int REG_DW      = 16;
    localparam int REG_AW      = 2;
    localparam int ALT_BIT     = 10;  // mode bit inside the system control word
    localparam int FO_STAT_BIT = 0;   // position of output 0 in the status word

    // 2-bit per-flag action code
    typedef enum logic [1:0] {
        FACT_KEEP = 2'b00,
        FACT_SET  = 2'b01,
        FACT_CLR  = 2'b10,
        FACT_TGL  = 2'b11
    } fact_e;

    typedef enum logic [REG_AW-1:0] {
        RA_SYSCTL = 2'd0,
        RA_STAT   = 2'd1,
        RA_PFDIR  = 2'd2,
        RA_PFDATA = 2'd3
    } raddr_e;

    typedef struct packed {
        logic              we;
        raddr_e            addr;
        logic [REG_DW-1:0] wdata;
    } bus_req_t;

    function automatic logic apply_act(input fact_e act, input logic cur);
        case (act)
            FACT_SET: return 1'b1;
            FACT_CLR: return 1'b0;
            FACT_TGL: return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/flag_out_unit.sv
module flag_out_unit
    import flagpin_pkg::*;
#(
    parameter int NUM_FLO = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_go_i,
    input  logic [2*NUM_FLO-1:0] act_i,
    output logic [NUM_FLO-1:0]   flags_o
);
    // Output 0: no reset term, it survives reset (R5)
    logic  fo_q;
    fact_e fo_code;
    assign fo_code = fact_e'(act_i[1:0]);

    always_ff @(posedge clk) begin
        if (!rst && op_go_i) fo_q <= apply_act(fo_code, fo_q);
    end
    assign flags_o[0] = fo_q;

    // Outputs 1..NUM_FLO-1: reset to 1 (R5), conditional action (R2)
    for (genvar i = 1; i < NUM_FLO; i++) begin : g_fl
        logic  q;
        fact_e code;
        assign code = fact_e'(act_i[2*i +: 2]);
        always_ff @(posedge clk) begin
            if (rst)          q <= 1'b1;
            else if (op_go_i) q <= apply_act(code, q);
        end
        assign flags_o[i] = q;
    end
endmodule

// File: rtl/pf_bank.sv
module pf_bank #(
    parameter int NUM_PF      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dir_we_i,
    input  logic              dat_we_i,
    input  logic [NUM_PF-1:0] wdata_i,
    input  logic [NUM_PF-1:0] pin_i,
    output logic [NUM_PF-1:0] dir_o,
    output logic [NUM_PF-1:0] lat_o,
    output logic [NUM_PF-1:0] rd_o
);
    logic [NUM_PF-1:0] dir_q, lat_q, pin_s;

    flag_sync #(.W(NUM_PF), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;                       // all inputs (R8)
            lat_q <= '0;
        end else begin
            if (dir_we_i) dir_q <= wdata_i;
            if (dat_we_i) lat_q <= wdata_i;    // regardless of direction (R10)
        end
    end

    for (genvar i = 0; i < NUM_PF; i++) begin : g_rd
        assign rd_o[i] = dir_q[i] ? lat_q[i] : pin_s[i];   // R9
    end

    assign dir_o = dir_q;
    assign lat_o = lat_q;
endmodule

// File: rtl/flagpin_ctrl.sv
module flagpin_ctrl
    import flagpin_pkg::*;
#(
    parameter int NUM_FLO     = 4,
    parameter int NUM_PF      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fi_pin_i,
    input  logic                 mod_strobe_i,
    input  logic                 cond_true_i,
    input  logic                 ce_eval_i,
    input  logic [2*NUM_FLO-1:0] flag_act_i,
    input  logic                 bus_we_i,
    input  logic [REG_AW-1:0]    bus_addr_i,
    input  logic [REG_DW-1:0]    bus_wdata_i,
    input  logic [NUM_PF-1:0]    pf_pin_i,
    output logic [NUM_FLO-1:0]   flag_out_o,
    output logic                 flag_in_o,
    output logic                 br_flag_in_o,
    output logic                 br_not_flag_in_o,
    output logic                 lc_dec_o,
    output logic                 alt_mode_o,
    output logic [NUM_PF-1:0]    pf_oe_o,
    output logic [NUM_PF-1:0]    pf_out_o,
    output logic [REG_DW-1:0]    bus_rdata_o
);
    bus_req_t          req;
    logic [REG_DW-1:0] sys_q;
    logic              fi_s, fin_q;
    logic [NUM_PF-1:0] pf_dir, pf_lat, pf_rd;

    assign req = '{we: bus_we_i, addr: raddr_e'(bus_addr_i), wdata: bus_wdata_i};

    // system control word, bit ALT_BIT selects pin function (R7)
    always_ff @(posedge clk) begin
        if (rst)                              sys_q <= '0;
        else if (req.we && req.addr == RA_SYSCTL) sys_q <= req.wdata;
    end
    assign alt_mode_o = sys_q[ALT_BIT];

    // flag input capture (R1)
    flag_sync #(.W(1), .STAGES(SYNC_STAGES)) u_fi_sync (
        .clk(clk), .rst(rst), .d_i(fi_pin_i), .q_o(fi_s)
    );

    always_ff @(posedge clk) begin
        if (rst)             fin_q <= 1'b0;
        else if (alt_mode_o) fin_q <= fi_s;
    end
    assign flag_in_o        = fin_q;
    assign br_flag_in_o     = fin_q;
    assign br_not_flag_in_o = ~fin_q;

    // counter-expired evaluated by modify-flag must not decrement (R4)
    assign lc_dec_o = ce_eval_i & ~mod_strobe_i;

    flag_out_unit #(.NUM_FLO(NUM_FLO)) u_flo (
        .clk     (clk),
        .rst     (rst),
        .op_go_i (mod_strobe_i & cond_true_i),
        .act_i   (flag_act_i),
        .flags_o (flag_out_o)
    );

    pf_bank #(.NUM_PF(NUM_PF), .SYNC_STAGES(SYNC_STAGES)) u_pf (
        .clk      (clk),
        .rst      (rst),
        .dir_we_i (req.we && req.addr == RA_PFDIR),
        .dat_we_i (req.we && req.addr == RA_PFDATA),
        .wdata_i  (req.wdata[NUM_PF-1:0]),
        .pin_i    (pf_pin_i),
        .dir_o    (pf_dir),
        .lat_o    (pf_lat),
        .rd_o     (pf_rd)
    );
    assign pf_oe_o  = pf_dir;
    assign pf_out_o = pf_lat;

    // read multiplexer (R6, R7, R8, R9)
    always_comb begin
        bus_rdata_o = '0;
        case (req.addr)
            RA_SYSCTL: bus_rdata_o = sys_q;
            RA_STAT:   bus_rdata_o[FO_STAT_BIT] = flag_out_o[0];
            RA_PFDIR:  bus_rdata_o[NUM_PF-1:0] = pf_dir;
            RA_PFDATA: bus_rdata_o[NUM_PF-1:0] = pf_rd;
            default:   bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/flagpin_chk.sv
module flagpin_chk #(
    parameter int NUM_FLO = 4,
    parameter int NUM_PF  = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 mod_strobe_i,
    input logic                 cond_true_i,
    input logic [2*NUM_FLO-1:0] flag_act_i,
    input logic [NUM_FLO-1:0]   flag_out_o,
    input logic                 br_flag_in_o,
    input logic                 br_not_flag_in_o,
    input logic                 lc_dec_o,
    input logic                 alt_mode_o,
    input logic [NUM_PF-1:0]    pf_oe_o
);
    p_no_dec_r4: assert property (@(posedge clk) disable iff (rst)
        mod_strobe_i |-> !lc_dec_o);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mod_strobe_i && !cond_true_i) |=> $stable(flag_out_o));

    p_set_r2: assert property (@(posedge clk) disable iff (rst)
        (mod_strobe_i && cond_true_i && flag_act_i[1:0] == 2'b01) |=> flag_out_o[0]);

    p_tgl_r2: assert property (@(posedge clk) disable iff (rst)
        (mod_strobe_i && cond_true_i && flag_act_i[3:2] == 2'b11)
        |=> flag_out_o[1] != $past(flag_out_o[1]));

    p_fi_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !alt_mode_o |=> $stable(br_flag_in_o));

    p_br_pair_r1: assert property (@(posedge clk) disable iff (rst)
        br_flag_in_o != br_not_flag_in_o);

    logic seen_q = 1'b0;
    logic rst_q  = 1'b0;
    logic fo_q   = 1'b0;

    always @(posedge clk) begin
        if (seen_q && rst_q) begin
            p_fl_rst_r5: assert (&flag_out_o[NUM_FLO-1:1]) else $error("flag outputs not set by reset");
            p_fo_keep_r5: assert (flag_out_o[0] == fo_q) else $error("output 0 changed by reset");
            p_dir_rst_r8: assert (pf_oe_o == '0) else $error("direction not cleared by reset");
        end
        seen_q <= 1'b1;
        rst_q  <= rst;
        fo_q   <= flag_out_o[0];
    end
endmodule

bind flagpin_ctrl flagpin_chk #(.NUM_FLO(NUM_FLO), .NUM_PF(NUM_PF)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .mod_strobe_i     (mod_strobe_i),
    .cond_true_i      (cond_true_i),
    .flag_act_i       (flag_act_i),
    .flag_out_o       (flag_out_o),
    .br_flag_in_o     (br_flag_in_o),
    .br_not_flag_in_o (br_not_flag_in_o),
    .lc_dec_o         (lc_dec_o),
    .alt_mode_o       (alt_mode_o),
    .pf_oe_o          (pf_oe_o)
);

// File: tb/flagpin_ctrl_tb.sv
module flagpin_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, fi_pin, strobe, cond, ce_eval, we;
    logic [7:0]  act, pf_pin;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [3:0]  flo;
    logic        fin, brf, brn, lcd, alt;
    logic [7:0]  pf_oe, pf_out;
    logic [15:0] rdata;

    int total = 0;
    int bad   = 0;
    bit chk_en = 0;
    bit done   = 0;

    // behavioural reference model
    bit         m_fo, m_fo_known;
    bit [2:0]   m_fl;
    bit [15:0]  m_sys;
    bit [7:0]   m_dir, m_lat;
    bit         m_fin;
    bit         fq[$] = '{1'b0, 1'b0};
    bit [7:0]   pq[$] = '{8'h00, 8'h00};

    always #(CLK_PERIOD/2) clk = ~clk;

    flagpin_ctrl u_dut (
        .clk(clk), .rst(rst), .fi_pin_i(fi_pin), .mod_strobe_i(strobe),
        .cond_true_i(cond), .ce_eval_i(ce_eval), .flag_act_i(act),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .pf_pin_i(pf_pin),
        .flag_out_o(flo), .flag_in_o(fin), .br_flag_in_o(brf),
        .br_not_flag_in_o(brn), .lc_dec_o(lcd), .alt_mode_o(alt),
        .pf_oe_o(pf_oe), .pf_out_o(pf_out), .bus_rdata_o(rdata)
    );

    function automatic bit do_act(bit [1:0] c, bit cur);
        if (c == 2'b01) return 1'b1;
        if (c == 2'b10) return 1'b0;
        if (c == 2'b11) return ~cur;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_fl = 3'b111; m_sys = '0; m_dir = '0; m_lat = '0; m_fin = 1'b0;
            fq = '{1'b0, 1'b0}; pq = '{8'h00, 8'h00};
        end else begin
            if (m_sys[10]) m_fin = fq[0];
            if (strobe && cond) begin
                if (act[1:0] == 2'b01 || act[1:0] == 2'b10) m_fo_known = 1'b1;
                m_fo = do_act(act[1:0], m_fo);
                for (int i = 0; i < 3; i++) m_fl[i] = do_act(act[2*i+2 +: 2], m_fl[i]);
            end
            if (we) begin
                if (addr == 2'd0) m_sys = wdata;
                if (addr == 2'd2) m_dir = wdata[7:0];
                if (addr == 2'd3) m_lat = wdata[7:0];
            end
            fq.push_back(fi_pin); void'(fq.pop_front());
            pq.push_back(pf_pin); void'(pq.pop_front());
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (chk_en && !done) begin
            check("R2 flag outputs 1-3", {29'd0, flo[3:1]}, {29'd0, m_fl});
            if (m_fo_known) check("R2 flag output 0", {31'd0, flo[0]}, {31'd0, m_fo});
            check("R1 flag-in status", {31'd0, brf}, {31'd0, m_fin});
            check("R1 inverse branch", {31'd0, brn}, {31'd0, ~m_fin});
            check("R4 counter decrement", {31'd0, lcd}, {31'd0, ce_eval & ~strobe});
            check("R7 alt mode", {31'd0, alt}, {31'd0, m_sys[10]});
            check("R8 direction", {24'd0, pf_oe}, {24'd0, m_dir});
            check("R10 drive latches", {24'd0, pf_out}, {24'd0, m_lat});
            case (addr)
                2'd0: check("R7 sysctl read", {16'd0, rdata}, {16'd0, m_sys});
                2'd1: if (m_fo_known) check("R6 status read", {16'd0, rdata}, {31'd0, m_fo});
                2'd2: check("R8 direction read", {16'd0, rdata}, {24'd0, m_dir});
                default: check("R9 data read", {16'd0, rdata},
                               {24'd0, (m_dir & m_lat) | (~m_dir & pq[0])});
            endcase
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic op(bit [7:0] a, bit c);
        cyc(); strobe = 1'b1; cond = c; act = a;
        cyc(); strobe = 1'b0; cond = 1'b0; act = '0;
    endtask

    task automatic wr(bit [1:0] a, bit [15:0] d);
        cyc(); we = 1'b1; addr = a; wdata = d;
        cyc(); we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1; bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; fi_pin = 0; strobe = 0; cond = 0; ce_eval = 0; we = 0;
        act = '0; pf_pin = '0; addr = '0; wdata = '0;
        m_fo = 0; m_fo_known = 0;
        cyc(); cyc(); cyc();
        rst = 0; chk_en = 1;
        @(negedge clk);
        check("R5 reset flags", {28'd0, flo[3:1], 1'b0}, 32'h0000000E);
        check("R8 reset direction", {24'd0, pf_oe}, 32'd0);
        check("R7 reset alt", {31'd0, alt}, 32'd0);

        // R2: mixed codes: out0 set, out1 clear, out2 toggle, out3 keep
        op(8'b00_11_10_01, 1'b1);
        @(negedge clk); check("R2 mixed codes", {28'd0, flo}, 32'h9);
        // R3: toggle-all with condition false
        op(8'hFF, 1'b0);
        @(negedge clk); check("R3 cond false", {28'd0, flo}, 32'h9);
        op(8'hFF, 1'b1);
        @(negedge clk); check("R2 toggle all", {28'd0, flo}, 32'h6);

        // R4
        cyc(); ce_eval = 1; strobe = 0; #1;
        check("R4 plain test decrements", {31'd0, lcd}, 32'd1);
        strobe = 1; #1;
        check("R4 modify-flag no decrement", {31'd0, lcd}, 32'd0);
        strobe = 0; ce_eval = 0;

        // R6
        cyc(); addr = 2'd1; #1;
        check("R6 status read", {16'd0, rdata}, 32'd0);
        wr(2'd1, 16'hFFFF); addr = 2'd1;
        @(negedge clk);
        check("R6 write ignored flags", {28'd0, flo}, 32'h6);
        check("R6 write ignored status", {16'd0, rdata}, 32'd0);

        // R7 and R1
        wr(2'd0, 16'h0400); addr = 2'd0;
        @(negedge clk);
        check("R7 alt set", {31'd0, alt}, 32'd1);
        check("R7 sysctl readback", {16'd0, rdata}, 32'h0400);
        fi_pin = 1; repeat (4) cyc();
        @(negedge clk); check("R1 flag set after sync", {30'd0, brf, brn}, 32'h2);
        wr(2'd0, 16'h0000);
        fi_pin = 0; repeat (4) cyc();
        @(negedge clk); check("R1 status holds when mode off", {31'd0, brf}, 32'd1);
        wr(2'd0, 16'h0400);
        for (int i = 0; i < 40; i++) begin cyc(); fi_pin = 1'($urandom); end

        // R9 / R10
        wr(2'd2, 16'h0000);
        pf_pin = 8'h3C; addr = 2'd3; repeat (3) cyc();
        @(negedge clk); check("R9 input readback", {16'd0, rdata}, 32'h3C);
        wr(2'd3, 16'h00A5); addr = 2'd3;
        @(negedge clk);
        check("R10 latch written on inputs", {24'd0, pf_out}, 32'hA5);
        check("R10 read still pins", {16'd0, rdata}, 32'h3C);
        wr(2'd2, 16'h000F); addr = 2'd3;
        @(negedge clk);
        check("R9 mixed readback", {16'd0, rdata}, 32'h35);
        check("R8 direction drive", {24'd0, pf_oe}, 32'h0F);

        // random stretch
        for (int i = 0; i < 300; i++) begin
            cyc();
            strobe = 1'($urandom); cond = 1'($urandom); act = 8'($urandom);
            ce_eval = 1'($urandom); fi_pin = 1'($urandom); pf_pin = 8'($urandom);
            we = (($urandom % 4) == 0); addr = 2'($urandom); wdata = 16'($urandom);
        end
        cyc(); strobe = 0; cond = 0; we = 0; act = '0; ce_eval = 0;

        // R5: output 0 survives reset at both levels
        op(8'b00_00_00_01, 1'b1);
        cyc(); rst = 1; strobe = 1; cond = 1; act = 8'hFF;
        cyc(); rst = 0; strobe = 0; cond = 0; act = '0;
        @(negedge clk);
        check("R5 reset keeps output 0 high", {28'd0, flo}, 32'hF);
        check("R8 reset direction again", {24'd0, pf_oe}, 32'd0);
        op(8'b00_00_00_10, 1'b1);
        cyc(); rst = 1;
        cyc(); rst = 0;
        @(negedge clk);
        check("R5 reset keeps output 0 low", {28'd0, flo}, 32'hE);

        cyc();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule